// File: doc/BRIEF.md
# Cascadable Serial Boot Memory Reader

This block is the read side of a one-time-programmable serial memory that an SRAM-based FPGA reads to load its configuration at power-up. The contents sit in an array of 32-bit words. An internal bit counter walks the array in order, so the reader never supplies an address. Each rising clock edge moves the stream on by one bit, but only while the device is selected and not held in reset.

One input pin does two jobs. At its active level it resets the device and turns the data pad off. At the other level it lets the device drive the pad. A parameter picks which level counts as active. When the last bit of the array has been sent, the device lowers its cascade output and stops driving the data pad. A second device wired to that cascade output as its chip enable then carries the bitstream on, so several parts can form one larger image. The array contents are computed from the word index, so no table is stored, and the depth is a parameter.

Top module: `scfg_stream_rom`

## Requirements
- R1: While `rst_n` is high, `ce_n` is low, the shared pin is at its inactive level and fewer than DEPTH_WORDS*32 bits have been sent, each rising edge of `clk` moves the bit counter on by exactly one.
- R2: Bit number k of the stream (k counted from 0) is bit (31 - k mod 32) of word w = k div 32, so each word is sent most significant bit first. Word w holds ((w * 0x9E3779B1) mod 2^32) XOR 0xC3A50F96. When `data_oe` is high, `data_o` shows the bit at the current count.
- R3: While the shared pin `rst_oe` is at its active level, `data_oe` is low at once. The rising edge of `clk` seen at that level sets the counter to 0, whatever `ce_n` is.
- R4: With RST_POL = 1 a high level on `rst_oe` resets the device, and with RST_POL = 0 a low level does.
- R5: While `ce_n` is high, the counter keeps its value over any number of clock edges, `data_oe` is low and `cas_n` is high. Streaming carries on from the held bit when `ce_n` goes low again.
- R6: Once DEPTH_WORDS*32 bits have been sent, `cas_n` is low while `ce_n` is low, `data_oe` stays low, and further edges do not move the counter.
- R7: With the default DEPTH_WORDS of 1134, `cas_n` falls after exactly 36,288 enabled edges and not one edge earlier.
- R8: When `rst_n` is low at a rising edge, the counter goes to 0. While `rst_n` is low, `data_oe` is low and `cas_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock. The stream moves on at each rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| ce_n | input | 1 | Active-low chip enable. Gates counting and the data pad |
| rst_oe | input | 1 | Shared reset and output enable. Its active level is set by RST_POL |
| data_o | output | 1 | Serial data value for the pad |
| data_oe | output | 1 | Pad drive enable. When low, the pad is released to high impedance |
| cas_n | output | 1 | Active-low cascade enable for the next device in the chain |

## Verification
The hardest case to reach is the handoff at the full default depth. The cascade output can only fall after 36,288 enabled edges, so the bench clocks one full-size instance through its whole array. It checks every bit on the way and checks that `cas_n` is still high one edge before the end. A second instance, four words deep and with the opposite reset polarity, is swept through every bit of its array. On that instance the stimulus also pauses the stream with chip enable part-way through a word, pulses the shared pin both with and without chip enable, and keeps clocking after the end to show that the counter stays put.

// File: rtl/scfg_pkg.sv
// Package: shared widths and the computed fill pattern of the array.
// Assumes 32-bit words; the fill is a pure function of the word index.
package scfg_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_W = $clog2(WORD_W);
    localparam logic [31:0] FILL_MULT = 32'h9E37_79B1;
    localparam logic [31:0] FILL_SEED = 32'hC3A5_0F96;

    // Content of one array word, derived arithmetically from its index.
    function automatic logic [WORD_W-1:0] fill_word(input logic [31:0] idx);
        logic [31:0] prod;
        prod = idx * FILL_MULT;
        return prod ^ FILL_SEED;
    endfunction
endpackage

// File: rtl/scfg_addr_ctr.sv
// Bit counter: walks the array one bit per enabled edge and stops at the end.
// Assumes clr and rst_n are synchronous; TOTAL fits in ADDR_W bits.
module scfg_addr_ctr #(
    parameter int TOTAL  = 128,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] bit_idx,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] LAST_CNT = ADDR_W'(TOTAL);

    // End flag: high once every bit of the array has been sent.
    assign at_end = (bit_idx == LAST_CNT);

    // Counter update: clear first, then move on by one until the end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_idx <= '0;
        end else if (step && !at_end) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/scfg_word_src.sv
// Bit source: fetches the word at the current count and picks the bit, MSB first.
// Assumes the low LANE_W bits of the count are the position inside the word.
module scfg_word_src #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] bit_idx,
    output logic              bit_val
);
    import scfg_pkg::*;

    localparam int SEL_W = ADDR_W - LANE_W;

    logic [SEL_W-1:0]  word_sel;
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] pos;
    logic [WORD_W-1:0] word_val;

    // Split the count into word index and position inside the word.
    assign word_sel = bit_idx[ADDR_W-1:LANE_W];
    assign lane     = bit_idx[LANE_W-1:0];

    // Compute the word and take the bit from the top end first.
    always_comb begin
        word_val = fill_word(32'(word_sel));
        pos      = LANE_W'(WORD_W - 1) - lane;
        bit_val  = word_val[pos];
    end
endmodule

// File: rtl/scfg_pin_ctl.sv
// Pin control: decodes the shared reset/enable pin and drives pad and cascade.
// Assumes RST_POL names the level of rst_oe that means reset.
module scfg_pin_ctl #(
    parameter bit RST_POL = 1'b1
) (
    input  logic rst_n,
    input  logic rst_oe,
    input  logic ce_n,
    input  logic at_end,
    input  logic bit_val,
    output logic rst_act,
    output logic step,
    output logic drv_en,
    output logic data_o,
    output logic cas_n
);
    // Decode the shared pin and gate the counter and pad.
    always_comb begin
        rst_act = (rst_oe == RST_POL);
        step    = rst_n && !rst_act && !ce_n;
        drv_en  = step && !at_end;
        data_o  = drv_en & bit_val;
        cas_n   = !(rst_n && !ce_n && at_end);
    end
endmodule

// File: rtl/scfg_stream_rom.sv
// Top: serial boot memory reader with shared reset/enable pin and cascade out.
// Assumes the pad outside turns data_oe into a high-impedance state.
module scfg_stream_rom #(
    parameter int DEPTH_WORDS = 1134,
    parameter bit RST_POL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic rst_oe,
    output logic data_o,
    output logic data_oe,
    output logic cas_n
);
    import scfg_pkg::*;

    localparam int TOTAL  = DEPTH_WORDS * WORD_W;
    localparam int ADDR_W = $clog2(TOTAL + 1);

    logic [ADDR_W-1:0] bit_idx;
    logic              at_end;
    logic              rst_act;
    logic              step;
    logic              drv_en;
    logic              bit_val;

    scfg_addr_ctr #(.TOTAL(TOTAL), .ADDR_W(ADDR_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rst_act),
        .step    (step),
        .bit_idx (bit_idx),
        .at_end  (at_end)
    );

    scfg_word_src #(.ADDR_W(ADDR_W)) src_i (
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    scfg_pin_ctl #(.RST_POL(RST_POL)) pin_i (
        .rst_n   (rst_n),
        .rst_oe  (rst_oe),
        .ce_n    (ce_n),
        .at_end  (at_end),
        .bit_val (bit_val),
        .rst_act (rst_act),
        .step    (step),
        .drv_en  (drv_en),
        .data_o  (data_o),
        .cas_n   (cas_n)
    );

    // Pad enable follows the internal drive decision.
    assign data_oe = drv_en;
endmodule

// File: rtl/scfg_stream_rom_chk.sv
// Checker: temporal properties of the counter, pad and cascade output.
// Assumes it is bound into scfg_stream_rom and sees its count and drive enable.
module scfg_stream_rom_chk #(
    parameter int TOTAL   = 128,
    parameter int ADDR_W  = 8,
    parameter bit RST_POL = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              rst_oe,
    input logic              cas_n,
    input logic [ADDR_W-1:0] bit_idx,
    input logic              drv_en
);
    logic pin_reset;
    assign pin_reset = (rst_oe == RST_POL);

    AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pin_reset |=> (bit_idx == '0)); // R3
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_reset && !ce_n && (bit_idx < ADDR_W'(TOTAL))) |=> (bit_idx == $past(bit_idx) + 1'b1)); // R1
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_reset && ce_n) |=> $stable(bit_idx)); // R5
    AST_CAS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> cas_n); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= ADDR_W'(TOTAL)); // R6
    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !drv_en); // R6
endmodule

bind scfg_stream_rom scfg_stream_rom_chk #(
    .TOTAL   (TOTAL),
    .ADDR_W  (ADDR_W),
    .RST_POL (RST_POL)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .rst_oe  (rst_oe),
    .cas_n   (cas_n),
    .bit_idx (bit_idx),
    .drv_en  (drv_en)
);

// File: tb/scfg_stream_rom_tb_top.sv
module scfg_stream_rom_tb_top;
    localparam int CLK_PER   = 10;
    localparam int BIG_WORDS = 1134;
    localparam int SML_WORDS = 4;
    localparam int BIG_BITS  = BIG_WORDS * 32;
    localparam int SML_BITS  = SML_WORDS * 32;

    logic clk = 1'b0;
    logic rst_n;
    logic a_ce_n, a_oe;
    logic s_ce_n, s_oe;
    logic a_data, a_den, a_cas;
    logic s_data, s_den, s_cas;
    int   n_run  = 0;
    int   n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    scfg_stream_rom #(.DEPTH_WORDS(BIG_WORDS), .RST_POL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(a_ce_n), .rst_oe(a_oe),
        .data_o(a_data), .data_oe(a_den), .cas_n(a_cas)
    );

    scfg_stream_rom #(.DEPTH_WORDS(SML_WORDS), .RST_POL(1'b0)) dut_small_i (
        .clk(clk), .rst_n(rst_n), .ce_n(s_ce_n), .rst_oe(s_oe),
        .data_o(s_data), .data_oe(s_den), .cas_n(s_cas)
    );

    function automatic logic exp_bit(input int k);
        logic [31:0] w;
        logic [31:0] word;
        w    = 32'(k / 32);
        word = (w * 32'h9E37_79B1) ^ 32'hC3A5_0F96;
        return word[31 - (k % 32)];
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_PER/4);
    endtask

    task automatic chk_small_bit(input int k, input string req);
        chk(s_den == 1'b1, req, "small data_oe", int'(s_den), 1);
        chk(s_data == exp_bit(k), req, "small data bit", int'(s_data), int'(exp_bit(k)));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n  = 1'b0;
        a_ce_n = 1'b1; a_oe = 1'b1;
        s_ce_n = 1'b1; s_oe = 1'b0;
        tick(); tick();
        // R8: outputs quiet under system reset
        s_ce_n = 1'b0; a_ce_n = 1'b0; a_oe = 1'b0; s_oe = 1'b1;
        #1;
        chk(a_den == 1'b0, "R8", "big data_oe in reset", int'(a_den), 0);
        chk(s_den == 1'b0, "R8", "small data_oe in reset", int'(s_den), 0);
        chk(s_cas == 1'b1, "R8", "small cas_n in reset", int'(s_cas), 1);
        a_ce_n = 1'b1; a_oe = 1'b1;
        tick();
        rst_n = 1'b1;
        #1;
        // R1 R2: full sweep of the small array, MSB first per word
        for (int k = 0; k < SML_BITS; k++) begin
            chk_small_bit(k, "R2");
            chk(s_cas == 1'b1, "R1", "small cas_n mid stream", int'(s_cas), 1);
            tick();
        end
        // R6: end of array reached
        chk(s_cas == 1'b0, "R6", "small cas_n at end", int'(s_cas), 0);
        chk(s_den == 1'b0, "R6", "small data_oe at end", int'(s_den), 0);
        tick(); tick(); tick();
        chk(s_cas == 1'b0, "R6", "small cas_n after extra edges", int'(s_cas), 0);
        chk(s_den == 1'b0, "R6", "small data_oe after extra edges", int'(s_den), 0);
        // R5: deselect at end releases cascade
        s_ce_n = 1'b1;
        #1;
        chk(s_cas == 1'b1, "R5", "small cas_n deselected", int'(s_cas), 1);
        // R3 R4: low level on shared pin resets with RST_POL=0
        s_oe = 1'b0; s_ce_n = 1'b0;
        #1;
        chk(s_den == 1'b0, "R3", "small data_oe while pin active", int'(s_den), 0);
        tick();
        s_oe = 1'b1;
        #1;
        chk_small_bit(0, "R4");
        chk(s_cas == 1'b1, "R3", "small cas_n after pin reset", int'(s_cas), 1);
        // R5: pause mid word and resume from the held bit
        for (int i = 0; i < 5; i++) tick();
        s_ce_n = 1'b1;
        #1;
        chk(s_den == 1'b0, "R5", "small data_oe paused", int'(s_den), 0);
        chk(s_cas == 1'b1, "R5", "small cas_n paused", int'(s_cas), 1);
        tick(); tick(); tick();
        s_ce_n = 1'b0;
        #1;
        chk_small_bit(5, "R5");
        tick();
        chk_small_bit(6, "R1");
        // R3: pin reset with chip enable high still clears
        s_ce_n = 1'b1; s_oe = 1'b0;
        tick();
        s_oe = 1'b1; s_ce_n = 1'b0;
        #1;
        chk_small_bit(0, "R3");
        s_ce_n = 1'b1;
        // R7: full-depth default instance, every bit and the handoff edge
        a_oe = 1'b0; a_ce_n = 1'b0;
        #1;
        for (int k = 0; k < BIG_BITS; k++) begin
            chk(a_den == 1'b1 && a_data == exp_bit(k), "R7", "big data bit",
                int'(a_data), int'(exp_bit(k)));
            if (k == BIG_BITS - 1)
                chk(a_cas == 1'b1, "R7", "big cas_n one edge early", int'(a_cas), 1);
            tick();
        end
        chk(a_cas == 1'b0, "R7", "big cas_n at end", int'(a_cas), 0);
        chk(a_den == 1'b0, "R7", "big data_oe at end", int'(a_den), 0);
        // R4: high level resets with RST_POL=1
        a_oe = 1'b1;
        #1;
        chk(a_den == 1'b0, "R4", "big data_oe pin high", int'(a_den), 0);
        tick();
        a_oe = 1'b0;
        #1;
        chk(a_cas == 1'b1, "R4", "big cas_n after reset", int'(a_cas), 1);
        chk(a_den == 1'b1 && a_data == exp_bit(0), "R4", "big bit 0 after reset",
            int'(a_data), int'(exp_bit(0)));
        finish_run();
    end
endmodule